// File: doc/BRIEF.md
# Register Rename Unit with FIFO Free List

This block translates architectural integer register numbers into physical register numbers for an out-of-order core that renames at most one instruction per cycle. It keeps a speculative mapping table that rename reads and writes, a committed copy of that table that only commit updates, and a first-in first-out list of unused physical registers. The default sizing is 32 architectural registers on 64 physical registers: specifiers are 5 bits wide on the architectural side and 6 bits wide on the physical side.

The rename request is a valid/ready stream. Every output on the rename side is a combinational function of the request fields and the current state, so the consumer takes it in the cycle of the handshake (`ren_valid && ren_ready`). State changes only on a handshake. `ren_ready` stays low while the free list is empty or a flush is asserted. The requester holds `ren_valid` and its fields stable until it sees ready. Commit and flush are plain control pins with no back-pressure. Commit must come in program order and gives back the displaced physical register. A flush rewinds the speculative table and the free-list read pointer to committed state.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers 32 to 63 in ascending order, so the first destination handed out is 32. `ren_ready` is 1.
- R2: `ren_psrc1` and `ren_psrc2` show the current speculative mapping of `ren_src1` and `ren_src2`, including renames accepted in earlier cycles. Architectural register 0 always maps to physical register 0.
- R3: A handshake with `ren_has_dst`=1 and `ren_dst`≠0 returns the free-list head on `ren_pdst` and pops it. It returns the replaced mapping on `ren_old_pdst` with `ren_old_valid`=1, and later lookups of that register see the new mapping.
- R4: A request with `ren_has_dst`=0 or `ren_dst`=0 pops nothing and leaves the table unchanged. It drives `ren_pdst`=0 and `ren_old_valid`=0.
- R5: While the free list is empty, `ren_ready` is 0. A valid request in that state changes neither the mapping table nor the free list.
- R6: A commit with `cmt_has_dst`=1 and `cmt_dst`≠0 pushes `cmt_old_pdst` to the tail of the free list. Freed registers are handed out again only after every register that was already in the list.
- R7: `flush` makes the speculative table equal to the committed table. The committed table is written only by commits, at index `cmt_dst` with value `cmt_pdst`. Flush also rewinds the free-list head, so destinations allocated since the last commit are handed out again in their original order.
- R8: A commit in the same cycle as `flush` is included in the restored state: both its mapping and its pop count as committed.
- R9: `ren_ready` is 0 during `flush`, and no rename takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename can be accepted |
| ren_src1 | input | 5 | Architectural source 1 |
| ren_src2 | input | 5 | Architectural source 2 |
| ren_dst | input | 5 | Architectural destination |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_psrc1 | output | 6 | Physical source 1 |
| ren_psrc2 | output | 6 | Physical source 2 |
| ren_pdst | output | 6 | Newly allocated physical destination (0 if none) |
| ren_old_pdst | output | 6 | Physical register previously mapped to the destination |
| ren_old_valid | output | 1 | `ren_old_pdst` is meaningful |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_has_dst | input | 1 | Committing instruction wrote a destination |
| cmt_dst | input | 5 | Committed architectural destination |
| cmt_pdst | input | 6 | Physical register it was renamed to |
| cmt_old_pdst | input | 6 | Displaced physical register to free |
| flush | input | 1 | Roll back to committed state |

## Verification
The assertions check these on every cycle: ready is low when the free list is empty or a flush is active, a destination handshake lowers the free-list occupancy by one, a rename without a destination leaves occupancy alone, register 0 maps to 0, and a commit never overfills the list. Only the bench scenarios can show the values involved. These are the exact allocation order after reset, the order in which freed registers come back, the mapping seen after a flush, and the combined effect of a commit that lands on the same cycle as a flush.

// File: rtl/reg_rename_pkg.sv
package reg_rename_pkg;
  parameter int DEF_ARCH_REGS = 32;
  parameter int DEF_PHYS_REGS = 64;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int AW = 5,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a1,
  input  logic [AW-1:0] rd_a2,
  input  logic [AW-1:0] rd_a3,
  output logic [PW-1:0] rd_p1,
  output logic [PW-1:0] rd_p2,
  output logic [PW-1:0] rd_p3,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_a,
  input  logic [PW-1:0] wr_p,
  input  logic          cm_en,
  input  logic [AW-1:0] cm_a,
  input  logic [PW-1:0] cm_p,
  input  logic          flush
);
  logic [PW-1:0] spec_q [NUM_ARCH];
  logic [PW-1:0] bkp_q  [NUM_ARCH];

  assign rd_p1 = spec_q[rd_a1];
  assign rd_p2 = spec_q[rd_a2];
  assign rd_p3 = spec_q[rd_a3];

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
    logic cm_hit;
    logic wr_hit;
    assign cm_hit = cm_en && (cm_a == AW'(i));
    assign wr_hit = wr_en && (wr_a == AW'(i));

    // committed copy: only commits write it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bkp_q[i] <= PW'(i);
      else if (cm_hit) bkp_q[i] <= cm_p;
    end

    // speculative copy: flush restores committed state incl. same-cycle commit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      spec_q[i] <= PW'(i);
      else if (flush)  spec_q[i] <= cm_hit ? cm_p : bkp_q[i];
      else if (wr_hit) spec_q[i] <= wr_p;
    end
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int DEPTH = 32,
  parameter int BASE  = 32,
  parameter int PW    = 6,
  localparam int IW   = $clog2(DEPTH),
  localparam int PTRW = IW + 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_data,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  input  logic          commit_pop,
  input  logic          flush,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [PW-1:0]   mem_q [DEPTH];
  logic [PTRW-1:0] head_q, chead_q, tail_q;
  logic [PTRW-1:0] diff;

  assign diff      = tail_q - head_q;
  assign count     = CW'(diff);
  assign empty     = (diff == '0);
  assign head_data = mem_q[head_q[IW-1:0]];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= PW'(BASE + i);
      else if (push && tail_q[IW-1:0] == IW'(i))
        mem_q[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      chead_q <= '0;
      tail_q  <= PTRW'(DEPTH);
    end else begin
      if (push)       tail_q  <= tail_q + 1'b1;
      if (commit_pop) chead_q <= chead_q + 1'b1;
      if (flush)      head_q  <= chead_q + PTRW'(commit_pop);
      else if (pop)   head_q  <= head_q + 1'b1;
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import reg_rename_pkg::*;
#(
  parameter int NUM_ARCH = DEF_ARCH_REGS,
  parameter int NUM_PHYS = DEF_PHYS_REGS,
  localparam int AW  = $clog2(NUM_ARCH),
  localparam int PW  = $clog2(NUM_PHYS),
  localparam int FLD = NUM_PHYS - NUM_ARCH,
  localparam int CW  = $clog2(FLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_has_dst,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_psrc2,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_old_pdst,
  output logic          ren_old_valid,
  input  logic          cmt_valid,
  input  logic          cmt_has_dst,
  input  logic [AW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_pdst,
  input  logic [PW-1:0] cmt_old_pdst,
  input  logic          flush
);
  logic          need_dst, fire_dst, cmt_dst_en, fl_empty;
  logic [PW-1:0] fl_head, old_map;
  logic [CW-1:0] fl_count;

  assign need_dst   = ren_has_dst && (ren_dst != '0);
  assign ren_ready  = !fl_empty && !flush;
  assign fire_dst   = ren_valid && ren_ready && need_dst;
  assign cmt_dst_en = cmt_valid && cmt_has_dst && (cmt_dst != '0);

  assign ren_pdst      = need_dst ? fl_head : '0;
  assign ren_old_pdst  = need_dst ? old_map : '0;
  assign ren_old_valid = need_dst;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_a1 (ren_src1),
    .rd_a2 (ren_src2),
    .rd_a3 (ren_dst),
    .rd_p1 (ren_psrc1),
    .rd_p2 (ren_psrc2),
    .rd_p3 (old_map),
    .wr_en (fire_dst),
    .wr_a  (ren_dst),
    .wr_p  (fl_head),
    .cm_en (cmt_dst_en),
    .cm_a  (cmt_dst),
    .cm_p  (cmt_pdst),
    .flush (flush)
  );

  rename_free_list #(.DEPTH(FLD), .BASE(NUM_ARCH), .PW(PW)) u_fl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop        (fire_dst),
    .head_data  (fl_head),
    .push       (cmt_dst_en),
    .push_data  (cmt_old_pdst),
    .commit_pop (cmt_dst_en),
    .flush      (flush),
    .count      (fl_count),
    .empty      (fl_empty)
  );
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int AW = 5,
  parameter int PW = 6,
  parameter int FLD = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_ready,
  input logic [AW-1:0] ren_src1,
  input logic [AW-1:0] ren_dst,
  input logic          ren_has_dst,
  input logic [PW-1:0] ren_psrc1,
  input logic [PW-1:0] ren_pdst,
  input logic [PW-1:0] ren_old_pdst,
  input logic          cmt_valid,
  input logic          cmt_has_dst,
  input logic [AW-1:0] cmt_dst,
  input logic          flush,
  input logic [CW-1:0] fl_count
);
  logic hs_dst, hs_nodst, cm_dst;
  assign hs_dst   = ren_valid && ren_ready && ren_has_dst && ren_dst != '0;
  assign hs_nodst = ren_valid && ren_ready && !(ren_has_dst && ren_dst != '0);
  assign cm_dst   = cmt_valid && cmt_has_dst && cmt_dst != '0;

  p_ready_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count == '0) |-> !ren_ready);

  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

  p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_dst && !cm_dst && !flush) |=> fl_count == $past(fl_count) - 1'b1);

  p_fresh_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_dst |-> ren_pdst != ren_old_pdst);

  p_nodst_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_nodst && !cm_dst && !flush) |=> $stable(fl_count));

  p_x0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_src1 == '0) |-> ren_psrc1 == '0);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_dst && !hs_dst) |-> fl_count < CW'(FLD));
endmodule

bind reg_rename reg_rename_chk #(.AW(AW), .PW(PW), .FLD(FLD), .CW(CW)) u_chk (.*);

// File: tb/tb_reg_rename.sv
module tb_reg_rename;
  logic       clk = 0, rst_n = 0;
  logic       ren_valid = 0, ren_has_dst = 0;
  logic [4:0] ren_src1 = 0, ren_src2 = 0, ren_dst = 0;
  logic       ren_ready, ren_old_valid;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst, ren_old_pdst;
  logic       cmt_valid = 0, cmt_has_dst = 0, flush = 0;
  logic [4:0] cmt_dst = 0;
  logic [5:0] cmt_pdst = 0, cmt_old_pdst = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  reg_rename dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ren_valid = 0; cmt_valid = 0; flush = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // one rename handshake; checks outputs before the edge
  task automatic ren(int s1, int s2, int d, bit hd, int e1, int e2, int epd, int eold, string tag);
    @(negedge clk);
    ren_src1 = 5'(s1); ren_src2 = 5'(s2); ren_dst = 5'(d); ren_has_dst = hd; ren_valid = 1;
    #1;
    chk({tag, " ready"}, ren_ready, 1);
    if (e1 >= 0) chk({tag, " psrc1"}, ren_psrc1, e1);
    if (e2 >= 0) chk({tag, " psrc2"}, ren_psrc2, e2);
    if (epd >= 0) chk({tag, " pdst"}, ren_pdst, epd);
    if (eold >= 0) chk({tag, " old_pdst"}, ren_old_pdst, eold);
    @(posedge clk); #1 ren_valid = 0;
  endtask

  task automatic look(int s1, int s2, int e1, int e2, string tag);
    @(negedge clk);
    ren_valid = 0; ren_src1 = 5'(s1); ren_src2 = 5'(s2);
    #1;
    chk({tag, " psrc1"}, ren_psrc1, e1);
    chk({tag, " psrc2"}, ren_psrc2, e2);
  endtask

  task automatic commit(int d, int pd, int old, bit fl);
    @(negedge clk);
    cmt_valid = 1; cmt_has_dst = 1; cmt_dst = 5'(d); cmt_pdst = 6'(pd); cmt_old_pdst = 6'(old); flush = fl;
    @(posedge clk); #1 cmt_valid = 0; flush = 0;
  endtask

  task automatic t_reset();
    do_reset();
    look(5, 31, 5, 31, "R1 identity");
    chk("R1 ready", ren_ready, 1);
    ren_dst = 3; ren_has_dst = 1; #1;
    chk("R1 first pdst", ren_pdst, 32);
    look(0, 0, 0, 0, "R2 x0");
  endtask

  task automatic t_basic();
    do_reset();
    ren(1, 2, 3, 1, 1, 2, 32, 3, "R3 first");
    look(3, 4, 32, 4, "R2 after rename");
    ren(3, 3, 3, 1, 32, 32, 33, 32, "R3 second");
    look(3, 0, 33, 0, "R2 newest");
  endtask

  task automatic t_nodst();
    do_reset();
    ren(1, 2, 0, 1, 1, 2, 0, -1, "R4 x0 dst");
    chk("R4 x0 old_valid", ren_old_valid, 0);
    ren(1, 2, 7, 0, 1, 2, 0, -1, "R4 no dst");
    chk("R4 nodst old_valid", ren_old_valid, 0);
    look(7, 0, 7, 0, "R4 table kept");
    ren(1, 2, 7, 1, -1, -1, 32, 7, "R4 no pop");
  endtask

  task automatic t_empty();
    do_reset();
    for (int k = 0; k < 32; k++)
      ren(0, 0, 1, 1, -1, -1, 32 + k, (k == 0) ? 1 : 31 + k, "R5 fill");
    @(negedge clk); #1;
    chk("R5 ready low when empty", ren_ready, 0);
    ren_src1 = 2; ren_dst = 2; ren_has_dst = 1; ren_valid = 1;
    @(posedge clk); #1 ren_valid = 0;
    look(2, 1, 2, 63, "R5 refused request no effect");
    commit(1, 32, 1, 0);
    ren(0, 0, 4, 1, -1, -1, 1, 4, "R5 R6 freed reused");
  endtask

  task automatic t_order();
    do_reset();
    ren(0, 0, 5, 1, -1, -1, 32, 5, "R6 a");
    ren(0, 0, 6, 1, -1, -1, 33, 6, "R6 b");
    commit(5, 32, 5, 0);
    commit(6, 33, 6, 0);
    for (int k = 0; k < 30; k++) ren(0, 0, 11, 1, -1, -1, 34 + k, -1, "R6 drain");
    ren(0, 0, 11, 1, -1, -1, 5, -1, "R6 recycled first");
    ren(0, 0, 11, 1, -1, -1, 6, -1, "R6 recycled second");
  endtask

  task automatic t_flush();
    do_reset();
    ren(0, 0, 7, 1, -1, -1, 32, 7, "R7 a");
    commit(7, 32, 7, 0);
    ren(0, 0, 7, 1, -1, -1, 33, 32, "R7 b");
    ren(0, 0, 8, 1, -1, -1, 34, 8, "R7 c");
    @(negedge clk); flush = 1; #1;
    chk("R9 ready low in flush", ren_ready, 0);
    @(posedge clk); #1 flush = 0;
    look(7, 8, 32, 8, "R7 restored");
    ren(0, 0, 9, 1, -1, -1, 33, 9, "R7 head rewound");
    ren(0, 0, 9, 1, -1, -1, 34, 33, "R7 head rewound next");
  endtask

  task automatic t_flush_commit();
    do_reset();
    ren(0, 0, 9, 1, -1, -1, 32, 9, "R8 a");
    ren(0, 0, 10, 1, -1, -1, 33, 10, "R8 b");
    commit(9, 32, 9, 1);
    look(9, 10, 32, 10, "R8 commit kept");
    ren(0, 0, 12, 1, -1, -1, 33, 12, "R8 head after commit");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_nodst();
    t_empty();
    t_order();
    t_flush();
    t_flush_commit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule